// File: doc/BRIEF.md
# Power-Managed Mode Clock Controller

This controller decides, cycle by cycle, whether the CPU and the peripherals receive clock enables and which source feeds them. A single sleep strobe either enters full Sleep, where everything stops and the primary oscillator is turned off, or one of the Idle modes, where only the CPU is held and the peripherals keep running from the source named in a 3-bit mode register. The mode register has an idle-enable bit and a 2-bit clock-select field.

Wake events (interrupt, watchdog time-out, reset) bring the block back to run. After Sleep, the system waits unclocked for the primary oscillator. If fast start is enabled, it runs from the internal oscillator in the meantime. After Idle, a fixed delay of about 10 µs elapses before the CPU enable returns, and the CPU then runs from the Idle source. Whenever the system is running from a source other than the primary after a wake-up, it hands over to the primary clock and raises the oscillator-start flag as soon as the primary reports ready. The block runs on an always-on reference clock, and the source-select output drives an external glitch-free mux.

Top module: `pm_clk_ctrl`

## Requirements
- R1: After asynchronous reset, mode_o is 000. With pri_rdy_i low and fast_start_en_i low, cpu_clk_en_o and per_clk_en_o are 0, clk_src_o is 00, osc_start_o is 0 and pri_osc_en_o is 1.
- R2: While running (cpu_clk_en_o=1), a sleep strobe with mode bit 2 (idle enable) at 0 enters Sleep on the next cycle. In Sleep, cpu_clk_en_o, per_clk_en_o, pri_osc_en_o and osc_start_o are all 0.
- R3: While running, a sleep strobe with mode bit 2 at 1 enters Idle on the next cycle, with cpu_clk_en_o=0 and per_clk_en_o=1. In Idle, clk_src_o follows mode bits 1:0: 00 gives 00 (primary), 01 gives 01 (secondary), and 1x gives 10 (internal).
- R4: Only wake_irq_i or wake_wdt_i leaves Sleep or Idle; with neither, the block stays put. In run, both inputs have no effect on any output.
- R5: After a wake from Sleep with fast_start_en_i=0, both enables stay 0 until pri_rdy_i is seen high. One cycle after that, cpu_clk_en_o=per_clk_en_o=1, clk_src_o=00 and osc_start_o=1.
- R6: After a wake from Sleep with fast_start_en_i=1 and the primary not ready, the block runs from the internal source (clk_src_o=10) from the second cycle after the wake. One cycle after pri_rdy_i is seen high, clk_src_o=00 and osc_start_o=1.
- R7: After a wake from Idle, cpu_clk_en_o rises on the (DLY_CYC+1)-th rising edge after the wake is presented. DLY_CYC is REF_CLK_KHZ*10/1000 rounded up, which is 10 by default. Through the delay, per_clk_en_o stays 1 and clk_src_o stays at the Idle source.
- R8: After an Idle wake from a non-primary source, clk_src_o holds that source while pri_rdy_i is low. One cycle after pri_rdy_i is seen high, it switches to 00 with osc_start_o=1. While the CPU is enabled, clk_src_o changes at no other time.
- R9: Interrupt and watchdog wake events leave mode_o unchanged.
- R10: wake_rst_i, in any state, clears mode_o to 000 and returns the block to the wait-for-primary state of R1 on the next cycle.
- R11: A sleep strobe presented while cpu_clk_en_o is 0 is ignored. Once the wake-up completes, the block is running.
- R12: mode_we_i loads mode_wdata_i into mode_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep command strobe |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 3 | Mode write data: bit 2 idle enable, bits 1:0 clock select |
| wake_irq_i | input | 1 | Interrupt wake event |
| wake_wdt_i | input | 1 | Watchdog time-out wake event |
| wake_rst_i | input | 1 | Reset wake event |
| pri_rdy_i | input | 1 | Primary oscillator ready |
| fast_start_en_i | input | 1 | Two-speed start / fail-safe enable |
| mode_o | output | 3 | Mode register contents |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| clk_src_o | output | 2 | Selected clock source |
| osc_start_o | output | 1 | Oscillator start status flag |
| pri_osc_en_o | output | 1 | Primary oscillator enable |

## Verification
The hardest cases to reach are a sleep strobe arriving in the middle of the Idle wake delay, and a post-wake run from a non-primary source while the primary is still not ready. The bench plays the oscillator: it drops pri_rdy_i at chosen points. It also pulses sleep_i a fixed number of cycles into the wake delay, so both cases occur across randomly chosen modes, wake types and fast-start settings. The delay length is measured by counting edges until the CPU enable returns.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;
  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01,
    SRC_INT = 2'b10
  } clk_src_e;

  typedef enum logic [2:0] {
    ST_WPRI,
    ST_RUN,
    ST_SLEEP,
    ST_IDLE,
    ST_WDLY
  } pm_state_e;

  typedef struct packed {
    logic       idle_en;
    logic [1:0] sel;
  } pm_mode_t;

  function automatic clk_src_e sel_to_src(logic [1:0] sel);
    if (sel[1]) return SRC_INT;
    if (sel[0]) return SRC_SEC;
    return SRC_PRI;
  endfunction
endpackage

// File: rtl/pm_mode_reg.sv
module pm_mode_reg
  import pm_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  pm_mode_t wdata_i,
  input  logic     clr_i,
  output pm_mode_t mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_o <= '0;
    else if (clr_i) mode_o <= '0;
    else if (we_i)  mode_o <= wdata_i;
  end

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(mode_o));
  p_mode_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mode_o == '0));
  p_mode_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> (mode_o == $past(wdata_i)));
endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
  parameter int unsigned DLY_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  output logic done_o
);
  localparam int unsigned CW = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC);
  localparam logic [CW-1:0] LOAD = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i)               cnt_q <= LOAD;
    else if (busy_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
  p_cnt_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pm_clk_fsm.sv
module pm_clk_fsm
  import pm_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sleep_i,
  input  pm_mode_t mode_i,
  input  logic     wake_i,
  input  logic     rst_wk_i,
  input  logic     pri_rdy_i,
  input  logic     fast_en_i,
  input  logic     dly_done_i,
  output logic     dly_start_o,
  output logic     dly_busy_o,
  output logic     cpu_en_o,
  output logic     per_en_o,
  output clk_src_e src_o,
  output logic     osts_o,
  output logic     pri_osc_en_o
);
  pm_state_e state_q;
  logic      pend_q;  // handover to primary outstanding

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WPRI;
      src_o   <= SRC_PRI;
      osts_o  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (rst_wk_i) begin
      state_q <= ST_WPRI;
      src_o   <= SRC_PRI;
      osts_o  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (sleep_i) begin
            pend_q <= 1'b0;
            if (mode_i.idle_en) begin
              state_q <= ST_IDLE;
              src_o   <= sel_to_src(mode_i.sel);
            end else begin
              state_q <= ST_SLEEP;
              osts_o  <= 1'b0;
            end
          end else if (pend_q && pri_rdy_i) begin
            src_o  <= SRC_PRI;
            osts_o <= 1'b1;
            pend_q <= 1'b0;
          end
        end
        ST_SLEEP: if (wake_i) begin
          state_q <= ST_WPRI;
          src_o   <= SRC_PRI;
        end
        ST_IDLE: if (wake_i) state_q <= ST_WDLY;
        ST_WDLY: if (dly_done_i) begin
          state_q <= ST_RUN;
          pend_q  <= (src_o != SRC_PRI);
        end
        ST_WPRI: begin
          if (pri_rdy_i) begin
            state_q <= ST_RUN;
            src_o   <= SRC_PRI;
            osts_o  <= 1'b1;
            pend_q  <= 1'b0;
          end else if (fast_en_i) begin
            state_q <= ST_RUN;
            src_o   <= SRC_INT;
            pend_q  <= 1'b1;
          end
        end
        default: state_q <= ST_WPRI;
      endcase
    end
  end

  assign dly_start_o  = (state_q == ST_IDLE) && wake_i && !rst_wk_i;
  assign dly_busy_o   = (state_q == ST_WDLY);
  assign cpu_en_o     = (state_q == ST_RUN);
  assign per_en_o     = (state_q == ST_RUN) || (state_q == ST_IDLE) || (state_q == ST_WDLY);
  assign pri_osc_en_o = (state_q != ST_SLEEP);

  p_sleep_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && sleep_i && !mode_i.idle_en && !rst_wk_i)
      |=> (!per_en_o && !osts_o && !pri_osc_en_o));
  p_idle_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && sleep_i && mode_i.idle_en && !rst_wk_i)
      |=> (per_en_o && !cpu_en_o && src_o == sel_to_src($past(mode_i.sel))));
  p_run_ignores_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && !sleep_i && !rst_wk_i) |=> cpu_en_o);
  p_unclocked_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WPRI && !pri_rdy_i && !fast_en_i && !rst_wk_i) |=> (!cpu_en_o && !per_en_o));
  p_src_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && $past(cpu_en_o) && !$stable(src_o)) |-> (src_o == SRC_PRI && osts_o));
  p_sleep_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_busy_o && !dly_done_i && !rst_wk_i) |=> dly_busy_o);
endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pm_clk_pkg::*;
#(
  parameter int unsigned REF_CLK_KHZ = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       mode_we_i,
  input  logic [2:0] mode_wdata_i,
  input  logic       wake_irq_i,
  input  logic       wake_wdt_i,
  input  logic       wake_rst_i,
  input  logic       pri_rdy_i,
  input  logic       fast_start_en_i,
  output logic [2:0] mode_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic [1:0] clk_src_o,
  output logic       osc_start_o,
  output logic       pri_osc_en_o
);
  // reference cycles in 10 us, rounded up, at least one
  localparam int unsigned DLY_RAW = (REF_CLK_KHZ * 10 + 999) / 1000;
  localparam int unsigned DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;

  pm_mode_t mode_q;
  clk_src_e src;
  logic     dly_start, dly_busy, dly_done;

  pm_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (pm_mode_t'(mode_wdata_i)),
    .clr_i   (wake_rst_i),
    .mode_o  (mode_q)
  );

  pm_wake_timer #(.DLY_CYC(DLY_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dly_start),
    .busy_i  (dly_busy),
    .done_o  (dly_done)
  );

  pm_clk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_i      (sleep_i),
    .mode_i       (mode_q),
    .wake_i       (wake_irq_i || wake_wdt_i),
    .rst_wk_i     (wake_rst_i),
    .pri_rdy_i    (pri_rdy_i),
    .fast_en_i    (fast_start_en_i),
    .dly_done_i   (dly_done),
    .dly_start_o  (dly_start),
    .dly_busy_o   (dly_busy),
    .cpu_en_o     (cpu_clk_en_o),
    .per_en_o     (per_clk_en_o),
    .src_o        (src),
    .osts_o       (osc_start_o),
    .pri_osc_en_o (pri_osc_en_o)
  );

  assign mode_o    = mode_q;
  assign clk_src_o = src;

  p_wake_keeps_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wake_irq_i || wake_wdt_i) && !wake_rst_i && !mode_we_i) |=> $stable(mode_o));
  p_rst_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_rst_i |=> (mode_o == 3'b000 && !cpu_clk_en_o && !osc_start_o && clk_src_o == 2'b00));
endmodule

// File: tb/pm_clk_ctrl_bench.sv
module pm_clk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_KHZ = 1000;
  localparam int DLY = (REF_KHZ * 10 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0, mode_we_i = 1'b0;
  logic [2:0] mode_wdata_i = '0;
  logic       wake_irq_i = 1'b0, wake_wdt_i = 1'b0, wake_rst_i = 1'b0;
  logic       pri_rdy_i = 1'b0, fast_start_en_i = 1'b0;
  logic [2:0] mode_o;
  logic       cpu_clk_en_o, per_clk_en_o, osc_start_o, pri_osc_en_o;
  logic [1:0] clk_src_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_clk_ctrl #(.REF_CLK_KHZ(REF_KHZ)) u_pm_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .mode_we_i(mode_we_i),
    .mode_wdata_i(mode_wdata_i), .wake_irq_i(wake_irq_i), .wake_wdt_i(wake_wdt_i),
    .wake_rst_i(wake_rst_i), .pri_rdy_i(pri_rdy_i), .fast_start_en_i(fast_start_en_i),
    .mode_o(mode_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .clk_src_o(clk_src_o), .osc_start_o(osc_start_o), .pri_osc_en_o(pri_osc_en_o)
  );

  function automatic int exp_src(logic [1:0] sel);
    if (sel[1]) return 2;
    if (sel[0]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(logic [2:0] m);
    mode_we_i = 1'b1; mode_wdata_i = m; cyc(1); mode_we_i = 1'b0;
    chk("R12 mode write", int'(mode_o), int'(m));
  endtask

  task automatic pulse_sleep();
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
  endtask

  task automatic pulse_wake(bit use_wdt);
    if (use_wdt) wake_wdt_i = 1'b1; else wake_irq_i = 1'b1;
    cyc(1);
    wake_wdt_i = 1'b0; wake_irq_i = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 cpu_en", int'(cpu_clk_en_o), 0);
    chk("R1 per_en", int'(per_clk_en_o), 0);
    chk("R1 src", int'(clk_src_o), 0);
    chk("R1 osts", int'(osc_start_o), 0);
    chk("R1 pri_osc_en", int'(pri_osc_en_o), 1);
    pri_rdy_i = 1'b1; cyc(1);
    chk("R5 run after ready cpu", int'(cpu_clk_en_o), 1);
    chk("R5 run after ready osts", int'(osc_start_o), 1);

    // R4 wake events ignored in run
    wake_irq_i = 1'b1; wake_wdt_i = 1'b1; cyc(1); wake_irq_i = 1'b0; wake_wdt_i = 1'b0;
    chk("R4 run cpu", int'(cpu_clk_en_o), 1);
    chk("R4 run src", int'(clk_src_o), 0);
    chk("R4 run osts", int'(osc_start_o), 1);
    chk("R9 run mode", int'(mode_o), 0);

    // directed full sleep
    wr_mode(3'b000);
    pulse_sleep();
    chk("R2 cpu", int'(cpu_clk_en_o), 0);
    chk("R2 per", int'(per_clk_en_o), 0);
    chk("R2 pri_osc_en", int'(pri_osc_en_o), 0);
    chk("R2 osts", int'(osc_start_o), 0);
    pri_rdy_i = 1'b0;
    cyc(3);
    chk("R4 no wake stays", int'(per_clk_en_o), 0);
    pulse_wake(1'b1);
    chk("R5 wait cpu", int'(cpu_clk_en_o), 0);
    chk("R5 wait osc_en", int'(pri_osc_en_o), 1);
    pulse_sleep();
    cyc(2);
    chk("R11 still waiting", int'(cpu_clk_en_o), 0);
    pri_rdy_i = 1'b1; cyc(1);
    chk("R5 cpu", int'(cpu_clk_en_o), 1);
    chk("R5 osts", int'(osc_start_o), 1);
    chk("R5 src", int'(clk_src_o), 0);
    cyc(2);
    chk("R11 sleep dropped", int'(cpu_clk_en_o), 1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [2:0] m;
      bit fast, wdt, pr;
      int es, n, per_ok;
      m = 3'($urandom);
      fast = 1'($urandom);
      wdt = 1'($urandom);
      fast_start_en_i = fast;
      wr_mode(m);
      pulse_sleep();
      if (m[2]) begin
        es = exp_src(m[1:0]);
        chk("R3 cpu", int'(cpu_clk_en_o), 0);
        chk("R3 per", int'(per_clk_en_o), 1);
        chk("R3 src", int'(clk_src_o), es);
        pr = (es == 0) ? 1'b1 : 1'($urandom);
        pri_rdy_i = pr;
        cyc(int'($urandom % 4));
        pulse_wake(wdt);
        n = 1; per_ok = 1;
        while (!cpu_clk_en_o && n < 60) begin
          if (!per_clk_en_o || int'(clk_src_o) != es) per_ok = 0;
          sleep_i = (n == 2);
          cyc(1);
          n++;
        end
        sleep_i = 1'b0;
        chk("R7 delay edges", n, DLY + 1);
        chk("R7 per kept", per_ok, 1);
        chk("R7 src kept", int'(clk_src_o), es);
        if (es != 0 && !pr) begin
          cyc(2);
          chk("R8 hold src", int'(clk_src_o), es);
          pri_rdy_i = 1'b1;
        end
        cyc(1);
        chk("R8 handover src", int'(clk_src_o), 0);
        chk("R8 handover osts", int'(osc_start_o), 1);
        chk("R11 running", int'(cpu_clk_en_o), 1);
      end else begin
        chk("R2 cpu", int'(cpu_clk_en_o), 0);
        chk("R2 per", int'(per_clk_en_o), 0);
        chk("R2 pri_osc_en", int'(pri_osc_en_o), 0);
        chk("R2 osts", int'(osc_start_o), 0);
        pri_rdy_i = 1'b0;
        cyc(1 + int'($urandom % 3));
        pulse_wake(wdt);
        chk("R5 first cycle cpu", int'(cpu_clk_en_o), 0);
        if (fast) begin
          cyc(1);
          chk("R6 cpu", int'(cpu_clk_en_o), 1);
          chk("R6 src int", int'(clk_src_o), 2);
          cyc(int'($urandom % 4));
          chk("R6 src held", int'(clk_src_o), 2);
          pri_rdy_i = 1'b1; cyc(1);
          chk("R6 src pri", int'(clk_src_o), 0);
          chk("R6 osts", int'(osc_start_o), 1);
        end else begin
          cyc(1 + int'($urandom % 4));
          chk("R5 cpu off", int'(cpu_clk_en_o), 0);
          chk("R5 per off", int'(per_clk_en_o), 0);
          pri_rdy_i = 1'b1; cyc(1);
          chk("R5 cpu", int'(cpu_clk_en_o), 1);
          chk("R5 src", int'(clk_src_o), 0);
          chk("R5 osts", int'(osc_start_o), 1);
        end
      end
      chk("R9 mode kept", int'(mode_o), int'(m));
    end

    // R10 reset wake from idle
    fast_start_en_i = 1'b0;
    wr_mode(3'b110);
    pulse_sleep();
    pri_rdy_i = 1'b0;
    wake_rst_i = 1'b1; cyc(1); wake_rst_i = 1'b0;
    chk("R10 mode", int'(mode_o), 0);
    chk("R10 cpu", int'(cpu_clk_en_o), 0);
    chk("R10 per", int'(per_clk_en_o), 0);
    chk("R10 src", int'(clk_src_o), 0);
    chk("R10 osts", int'(osc_start_o), 0);
    pri_rdy_i = 1'b1; cyc(1);
    chk("R10 resume cpu", int'(cpu_clk_en_o), 1);
    finish_up();
  end
endmodule